// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits between a memory-mapped host port and the pins of a NAND flash target. The host loads a 32-bit flash address and a 32-bit write word into host-visible registers, then writes opcode bytes into a command slot. The sequencer checks each byte or byte pair and turns it into the matching target bus transaction. A transaction is made of command-latch cycles, address-latch cycles, write cycles and read cycles on a 16-bit target bus, with waits on the target's ready/busy line where the flash is working internally.

Page read, page program, block erase, identifier read, status read and target reset are supported. Every accepted operation ends with a one-cycle interrupt to the host. The host-side ready/busy output stays low while an operation runs. Results of identifier, status and page reads land in registers that the host reads back through the same port. Each target strobe is held low for a parameterised number of clocks and then high for the same number, so the bus can be slowed to meet target setup and hold needs.

Top module: `nfc_sequencer`

## Requirements
- R1: While the internal reset is active, and on the first cycles after it, host_irq is 0, host_rb_n is 1, tgt_ce_n, tgt_we_n and tgt_re_n are 1, and tgt_cle and tgt_ale are 0.
- R2: A host write (host_cs_n=0, host_wr_n=0) is taken as an opcode only at offset 0x000. Offset 0x004 loads the flash address and offset 0x010 loads the write word. Opcode bytes written to any other offset start nothing.
- R3: The two-byte operations start only when a confirm byte follows its own first byte: 00h then 30h is page read, 80h then 10h is page program, 60h then D0h is block erase. A confirm without its first byte, or after a different first byte, causes no target activity and no interrupt.
- R4: A two-byte operation drives these cycles in order: a command cycle (tgt_cle=1) with the first byte, then two address cycles (tgt_ale=1) carrying address bits 15:0 and then 31:16. Page program next drives two write cycles carrying write-word bits 15:0 and then 31:16. Last comes a command cycle with the confirm byte.
- R5: After the confirm cycle of read, program and erase, the sequencer waits for tgt_rb_n to go low and then high. It drives no strobe and raises no interrupt before that.
- R6: Page read, after the busy wait, drives two read cycles. The first word goes to bits 15:0 and the second to bits 31:16 of the read word at offset 0x010.
- R7: Read ID (90h) drives one command cycle and two read cycles, with no address cycle and no busy wait. It stores the first word in bits 15:0 and the second in bits 31:16 of the ID register at offset 0x008.
- R8: Read status (70h) drives one command cycle and one read cycle. The low byte of that word is stored in the status register, which reads back at offset 0x00C in bits 7:0 with zeros above.
- R9: Target reset (FFh) drives one command cycle and then the busy wait of R5, with no address or data cycles.
- R10: Each accepted operation raises host_irq for exactly one cycle. host_rb_n is 0 from the cycle after the accepted byte up to and including the interrupt cycle, and 1 afterwards.
- R11: Opcode writes while host_rb_n is 0 are ignored: they add no target cycles and no interrupt to the running operation.
- R12: A byte that is neither a first byte, a matching confirm nor a single-byte opcode causes no target activity and no interrupt. It also discards any stored first byte.
- R13: Each tgt_we_n or tgt_re_n low pulse lasts exactly STROBE_CYC clocks, tgt_ce_n is 0 whenever a strobe is low, and tgt_cle, tgt_ale and tgt_dout stay steady while a write strobe is low.
- R14: tgt_wp_n is 0 while the internal reset is active and 1 once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| host_rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, zero unless selected for reading |
| host_cs_n | input | 1 | Host select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_irq | output | 1 | One-cycle completion interrupt |
| host_rb_n | output | 1 | Ready (1) or busy (0) to the host |
| tgt_dout | output | 16 | Command, address or write data to the target |
| tgt_din | input | 16 | Read data from the target |
| tgt_ce_n | output | 1 | Target chip enable, active low |
| tgt_re_n | output | 1 | Target read strobe, active low |
| tgt_we_n | output | 1 | Target write strobe, active low |
| tgt_wp_n | output | 1 | Target write protect, active low |
| tgt_cle | output | 1 | Command latch enable |
| tgt_ale | output | 1 | Address latch enable |
| tgt_rb_n | input | 1 | Target ready (1) or busy (0) |

## Verification
The bench builds the sequencer with STROBE_CYC=2. This keeps every operation to a few dozen clocks, so all 256 opcode byte values can be swept one by one, along with every first-byte and confirm pairing. Each sweep step still measures the strobe pulse widths. A behavioural target logs every latched cycle, answers read strobes with a counting pattern and holds ready/busy low for a fixed time after a confirm or reset byte. From these the bench derives the expected cycle order, the register contents and the timing of the interrupt relative to the busy release.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int TD_W = 16;
  localparam int HD_W = 2 * TD_W;
  localparam int HA_W = 12;

  localparam logic [HA_W-1:0] OFS_CMD  = 12'h000;
  localparam logic [HA_W-1:0] OFS_ADDR = 12'h004;
  localparam logic [HA_W-1:0] OFS_ID   = 12'h008;
  localparam logic [HA_W-1:0] OFS_STAT = 12'h00C;
  localparam logic [HA_W-1:0] OFS_DATA = 12'h010;

  localparam logic [7:0] OP_RD1  = 8'h00;
  localparam logic [7:0] OP_RD2  = 8'h30;
  localparam logic [7:0] OP_PG1  = 8'h80;
  localparam logic [7:0] OP_PG2  = 8'h10;
  localparam logic [7:0] OP_ER1  = 8'h60;
  localparam logic [7:0] OP_ER2  = 8'hD0;
  localparam logic [7:0] OP_RID  = 8'h90;
  localparam logic [7:0] OP_STAT = 8'h70;
  localparam logic [7:0] OP_RST  = 8'hFF;

  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_WR, CYC_RD} cyc_e;
  typedef enum logic [2:0] {OPK_READ, OPK_PROG, OPK_ERASE, OPK_ID, OPK_STAT, OPK_RESET} opk_e;
  typedef enum logic [2:0] {SL_ID0, SL_ID1, SL_ST, SL_DAT0, SL_DAT1} slot_e;
  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_ADDR0, S_ADDR1, S_DATA0, S_DATA1,
    S_CONF, S_WLO, S_WHI, S_RD0, S_RD1, S_DONE
  } st_e;
endpackage

// File: rtl/nfc_host_regs.sv
module nfc_host_regs
  import nfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HA_W-1:0] host_addr,
  input  logic [HD_W-1:0] host_wdata,
  input  logic            host_cs_n,
  input  logic            host_wr_n,
  input  logic            host_rd_n,
  output logic [HD_W-1:0] host_rdata,
  output logic            cmd_wr,
  output logic [7:0]      cmd_byte,
  output logic [HD_W-1:0] addr_q,
  output logic [HD_W-1:0] wdat_q,
  input  logic            cap_en,
  input  slot_e           cap_slot,
  input  logic [TD_W-1:0] cap_val
);
  logic            wr_en;
  logic            addr_en;
  logic            wdat_en;
  logic [HD_W-1:0] id_q;
  logic [HD_W-1:0] rbuf_q;
  logic [7:0]      stat_q;

  assign wr_en    = !host_cs_n && !host_wr_n;
  assign cmd_wr   = wr_en && (host_addr == OFS_CMD);
  assign cmd_byte = host_wdata[7:0];
  assign addr_en  = wr_en && (host_addr == OFS_ADDR);
  assign wdat_en  = wr_en && (host_addr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      if (addr_en) addr_q <= host_wdata;
      if (wdat_en) wdat_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      rbuf_q <= '0;
      stat_q <= '0;
    end else if (cap_en) begin
      case (cap_slot)
        SL_ID0:  id_q[TD_W-1:0]      <= cap_val;
        SL_ID1:  id_q[HD_W-1:TD_W]   <= cap_val;
        SL_ST:   stat_q              <= cap_val[7:0];
        SL_DAT0: rbuf_q[TD_W-1:0]    <= cap_val;
        SL_DAT1: rbuf_q[HD_W-1:TD_W] <= cap_val;
        default: ;
      endcase
    end
  end

  always_comb begin
    host_rdata = '0;
    if (!host_cs_n && !host_rd_n) begin
      case (host_addr)
        OFS_ADDR: host_rdata = addr_q;
        OFS_ID:   host_rdata = id_q;
        OFS_STAT: host_rdata = HD_W'(stat_q);
        OFS_DATA: host_rdata = rbuf_q;
        default:  host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nfc_bus_cycle.sv
module nfc_bus_cycle
  import nfc_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cyc_e            kind,
  input  logic [TD_W-1:0] val,
  input  logic [TD_W-1:0] tgt_din,
  output logic            idle,
  output logic            done,
  output logic [TD_W-1:0] rd_val,
  output logic            tgt_cle,
  output logic            tgt_ale,
  output logic            tgt_we_n,
  output logic            tgt_re_n,
  output logic [TD_W-1:0] tgt_dout
);
  localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

  ph_e             ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  cyc_e            kind_q, kind_d;
  logic [TD_W-1:0] val_q, val_d;
  logic [TD_W-1:0] rd_q, rd_d;
  logic            active;
  logic            last;

  assign last = (cnt_q == CNT_LAST);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    val_d  = val_q;
    rd_d   = rd_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_LOW;
        cnt_d  = '0;
        kind_d = kind;
        val_d  = val;
      end
      PH_LOW: if (last) begin
        ph_d  = PH_HIGH;
        cnt_d = '0;
        if (kind_q == CYC_RD) rd_d = tgt_din;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_HIGH: if (last) begin
        ph_d = PH_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= CYC_CMD;
      val_q  <= '0;
      rd_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      val_q  <= val_d;
      rd_q   <= rd_d;
    end
  end

  assign active   = (ph_q != PH_IDLE);
  assign idle     = (ph_q == PH_IDLE);
  assign done     = (ph_q == PH_HIGH) && last;
  assign rd_val   = rd_q;
  assign tgt_cle  = active && (kind_q == CYC_CMD);
  assign tgt_ale  = active && (kind_q == CYC_ADDR);
  assign tgt_we_n = !((ph_q == PH_LOW) && (kind_q != CYC_RD));
  assign tgt_re_n = !((ph_q == PH_LOW) && (kind_q == CYC_RD));
  assign tgt_dout = (active && (kind_q != CYC_RD)) ? val_q : '0;

  logic [15:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else if (!tgt_we_n || !tgt_re_n) lo_run <= lo_run + 16'd1;
    else lo_run <= '0;
  end

  a_r13_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_we_n) || $rose(tgt_re_n)) |-> (lo_run == 16'(STROBE_CYC)));

  a_r13_steady_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_we_n && $past(!tgt_we_n)) |-> ($stable(tgt_dout) && $stable(tgt_cle) && $stable(tgt_ale)));

  a_r13_single_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgt_cle && tgt_ale));
endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [7:0]      cmd_byte,
  input  logic [HD_W-1:0] addr_q,
  input  logic [HD_W-1:0] wdat_q,
  input  logic            tgt_rb_n,
  input  logic            eng_idle,
  input  logic            eng_done,
  output logic            eng_start,
  output cyc_e            eng_kind,
  output logic [TD_W-1:0] eng_val,
  output logic            cap_en,
  output slot_e           cap_slot,
  output logic            host_irq,
  output logic            host_rb_n,
  output logic            tgt_ce_n,
  output logic            tgt_wp_n
);
  st_e        st_q, st_d;
  opk_e       opk_q, opk_d;
  logic       pend_q, pend_d;
  logic [7:0] pfx_q, pfx_d;
  logic       rb_m, rb_s;
  logic       wp_q;
  logic       bus_st;

  function automatic logic [7:0] first_byte(input opk_e k);
    case (k)
      OPK_READ:  return OP_RD1;
      OPK_PROG:  return OP_PG1;
      OPK_ERASE: return OP_ER1;
      OPK_ID:    return OP_RID;
      OPK_STAT:  return OP_STAT;
      default:   return OP_RST;
    endcase
  endfunction

  function automatic logic [7:0] conf_byte(input opk_e k);
    case (k)
      OPK_READ: return OP_RD2;
      OPK_PROG: return OP_PG2;
      default:  return OP_ER2;
    endcase
  endfunction

  always_comb begin
    st_d   = st_q;
    opk_d  = opk_q;
    pend_d = pend_q;
    pfx_d  = pfx_q;
    case (st_q)
      S_IDLE: if (cmd_wr) begin
        pend_d = 1'b0;
        if (cmd_byte == OP_RD1 || cmd_byte == OP_PG1 || cmd_byte == OP_ER1) begin
          pend_d = 1'b1;
          pfx_d  = cmd_byte;
        end else if (pend_q && pfx_q == OP_RD1 && cmd_byte == OP_RD2) begin
          opk_d = OPK_READ;  st_d = S_FIRST;
        end else if (pend_q && pfx_q == OP_PG1 && cmd_byte == OP_PG2) begin
          opk_d = OPK_PROG;  st_d = S_FIRST;
        end else if (pend_q && pfx_q == OP_ER1 && cmd_byte == OP_ER2) begin
          opk_d = OPK_ERASE; st_d = S_FIRST;
        end else if (cmd_byte == OP_RID) begin
          opk_d = OPK_ID;    st_d = S_FIRST;
        end else if (cmd_byte == OP_STAT) begin
          opk_d = OPK_STAT;  st_d = S_FIRST;
        end else if (cmd_byte == OP_RST) begin
          opk_d = OPK_RESET; st_d = S_FIRST;
        end
      end
      S_FIRST: if (eng_done) begin
        case (opk_q)
          OPK_READ, OPK_PROG, OPK_ERASE: st_d = S_ADDR0;
          OPK_ID, OPK_STAT:              st_d = S_RD0;
          default:                       st_d = S_WLO;
        endcase
      end
      S_ADDR0: if (eng_done) st_d = S_ADDR1;
      S_ADDR1: if (eng_done) st_d = (opk_q == OPK_PROG) ? S_DATA0 : S_CONF;
      S_DATA0: if (eng_done) st_d = S_DATA1;
      S_DATA1: if (eng_done) st_d = S_CONF;
      S_CONF:  if (eng_done) st_d = S_WLO;
      S_WLO:   if (!rb_s) st_d = S_WHI;
      S_WHI:   if (rb_s) st_d = (opk_q == OPK_READ) ? S_RD0 : S_DONE;
      S_RD0:   if (eng_done) st_d = (opk_q == OPK_STAT) ? S_DONE : S_RD1;
      S_RD1:   if (eng_done) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      opk_q  <= OPK_READ;
      pend_q <= 1'b0;
      pfx_q  <= '0;
      rb_m   <= 1'b1;
      rb_s   <= 1'b1;
      wp_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      opk_q  <= opk_d;
      pend_q <= pend_d;
      pfx_q  <= pfx_d;
      rb_m   <= tgt_rb_n;
      rb_s   <= rb_m;
      wp_q   <= 1'b1;
    end
  end

  always_comb begin
    eng_kind = CYC_CMD;
    eng_val  = '0;
    bus_st   = 1'b1;
    case (st_q)
      S_FIRST: eng_val = TD_W'(first_byte(opk_q));
      S_ADDR0: begin eng_kind = CYC_ADDR; eng_val = addr_q[TD_W-1:0];    end
      S_ADDR1: begin eng_kind = CYC_ADDR; eng_val = addr_q[HD_W-1:TD_W]; end
      S_DATA0: begin eng_kind = CYC_WR;   eng_val = wdat_q[TD_W-1:0];    end
      S_DATA1: begin eng_kind = CYC_WR;   eng_val = wdat_q[HD_W-1:TD_W]; end
      S_CONF:  eng_val = TD_W'(conf_byte(opk_q));
      S_RD0, S_RD1: eng_kind = CYC_RD;
      default: bus_st = 1'b0;
    endcase
  end

  always_comb begin
    cap_en = eng_done && (st_q == S_RD0 || st_q == S_RD1);
    case (opk_q)
      OPK_ID:   cap_slot = (st_q == S_RD1) ? SL_ID1 : SL_ID0;
      OPK_STAT: cap_slot = SL_ST;
      default:  cap_slot = (st_q == S_RD1) ? SL_DAT1 : SL_DAT0;
    endcase
  end

  assign eng_start = bus_st && eng_idle;
  assign host_irq  = (st_q == S_DONE);
  assign host_rb_n = (st_q == S_IDLE);
  assign tgt_ce_n  = (st_q == S_IDLE);
  assign tgt_wp_n  = wp_q;

  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  a_r10_busy_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !host_rb_n);

  a_r10_ready_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rb_n) |-> $past(host_irq));

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rb_n && !host_irq) |=> !host_rb_n);

  a_r12_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    host_rb_n |-> eng_idle);
endmodule

// File: rtl/nfc_sequencer.sv
module nfc_sequencer
  import nfc_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic        clk,
  input  logic        host_rst_n,
  input  logic [11:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        host_cs_n,
  input  logic        host_wr_n,
  input  logic        host_rd_n,
  output logic        host_irq,
  output logic        host_rb_n,
  output logic [15:0] tgt_dout,
  input  logic [15:0] tgt_din,
  output logic        tgt_ce_n,
  output logic        tgt_re_n,
  output logic        tgt_we_n,
  output logic        tgt_wp_n,
  output logic        tgt_cle,
  output logic        tgt_ale,
  input  logic        tgt_rb_n
);
  logic [1:0]      rs_q;
  logic            rst_n;
  logic            cmd_wr;
  logic [7:0]      cmd_byte;
  logic [HD_W-1:0] addr_q;
  logic [HD_W-1:0] wdat_q;
  logic            cap_en;
  slot_e           cap_slot;
  logic            eng_start;
  cyc_e            eng_kind;
  logic [TD_W-1:0] eng_val;
  logic            eng_idle;
  logic            eng_done;
  logic [TD_W-1:0] eng_rd;

  always_ff @(posedge clk or negedge host_rst_n) begin
    if (!host_rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  nfc_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_cs_n  (host_cs_n),
    .host_wr_n  (host_wr_n),
    .host_rd_n  (host_rd_n),
    .host_rdata (host_rdata),
    .cmd_wr     (cmd_wr),
    .cmd_byte   (cmd_byte),
    .addr_q     (addr_q),
    .wdat_q     (wdat_q),
    .cap_en     (cap_en),
    .cap_slot   (cap_slot),
    .cap_val    (eng_rd)
  );

  nfc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_byte  (cmd_byte),
    .addr_q    (addr_q),
    .wdat_q    (wdat_q),
    .tgt_rb_n  (tgt_rb_n),
    .eng_idle  (eng_idle),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_kind  (eng_kind),
    .eng_val   (eng_val),
    .cap_en    (cap_en),
    .cap_slot  (cap_slot),
    .host_irq  (host_irq),
    .host_rb_n (host_rb_n),
    .tgt_ce_n  (tgt_ce_n),
    .tgt_wp_n  (tgt_wp_n)
  );

  nfc_bus_cycle #(.STROBE_CYC(STROBE_CYC)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .kind     (eng_kind),
    .val      (eng_val),
    .tgt_din  (tgt_din),
    .idle     (eng_idle),
    .done     (eng_done),
    .rd_val   (eng_rd),
    .tgt_cle  (tgt_cle),
    .tgt_ale  (tgt_ale),
    .tgt_we_n (tgt_we_n),
    .tgt_re_n (tgt_re_n),
    .tgt_dout (tgt_dout)
  );

  a_r13_ce_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_we_n || !tgt_re_n) |-> !tgt_ce_n);
endmodule

// File: tb/nfc_sequencer_test.sv
module nfc_sequencer_test;
  localparam int CLK_P  = 10;
  localparam int STROBE = 2;
  localparam int BUSY_T = 6;

  logic        clk = 1'b0;
  logic        host_rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_cs_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        host_rd_n = 1'b1;
  logic        host_irq, host_rb_n;
  logic [15:0] tgt_dout;
  logic [15:0] tgt_din = '0;
  logic        tgt_ce_n, tgt_re_n, tgt_we_n, tgt_wp_n, tgt_cle, tgt_ale;
  logic        tgt_rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  nfc_sequencer #(.STROBE_CYC(STROBE)) uut (
    .clk(clk), .host_rst_n(host_rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .host_irq(host_irq), .host_rb_n(host_rb_n), .tgt_dout(tgt_dout), .tgt_din(tgt_din),
    .tgt_ce_n(tgt_ce_n), .tgt_re_n(tgt_re_n), .tgt_we_n(tgt_we_n), .tgt_wp_n(tgt_wp_n),
    .tgt_cle(tgt_cle), .tgt_ale(tgt_ale), .tgt_rb_n(tgt_rb_n)
  );

  always #(CLK_P/2) clk = ~clk;

  // target model: kinds 0 command, 1 address, 2 write data, 3 read
  logic [1:0]  logk [0:31];
  logic [15:0] logd [0:31];
  int          nlog = 0;
  logic [1:0]  ek [0:31];
  logic [15:0] ed [0:31];
  int          nexp = 0;
  int          irq_cnt = 0;
  int          cyc = 0;
  int          rb_rise_cyc = -1;
  int          first_rd_cyc = -1;
  int          irq_cyc = -1;
  int          busy_seen = 0;
  int          lo_len = 0;
  int          rd_idx = 0;
  logic [15:0] rd_base = '0;
  int          bdelay = 0;
  int          bcnt = 0;
  logic        we_prev = 1'b1;
  logic        re_prev = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (host_rst_n) begin
      if (host_irq) begin irq_cnt++; irq_cyc = cyc; end
      if (!tgt_we_n || !tgt_re_n) begin
        lo_len++;
        check(!tgt_ce_n, "R13", "ce_n during strobe", {31'd0, tgt_ce_n}, 32'd0);
      end
      if ((!we_prev && tgt_we_n) || (!re_prev && tgt_re_n)) begin
        check(lo_len == STROBE, "R13", "strobe low width", lo_len, STROBE);
        lo_len = 0;
      end
      if (!we_prev && tgt_we_n && nlog < 32) begin
        logk[nlog] = tgt_cle ? 2'd0 : (tgt_ale ? 2'd1 : 2'd2);
        logd[nlog] = tgt_dout;
        nlog++;
        if (tgt_cle && (tgt_dout == 16'h30 || tgt_dout == 16'h10 ||
                        tgt_dout == 16'hD0 || tgt_dout == 16'hFF)) bdelay = 2;
      end
      if (re_prev && !tgt_re_n) begin
        tgt_din = rd_base + 16'(rd_idx);
        if (first_rd_cyc < 0) first_rd_cyc = cyc;
        if (nlog < 32) begin logk[nlog] = 2'd3; logd[nlog] = tgt_din; nlog++; end
        rd_idx++;
      end
      if (bdelay > 0) begin
        bdelay--;
        if (bdelay == 0) begin tgt_rb_n = 1'b0; bcnt = BUSY_T; busy_seen = 1; end
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) begin tgt_rb_n = 1'b1; rb_rise_cyc = cyc; end
      end
    end
    we_prev = tgt_we_n;
    re_prev = tgt_re_n;
  end

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
    @(negedge clk);
    host_cs_n = 1'b1; host_wr_n = 1'b1;
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
    #1 d = host_rdata;
    host_cs_n = 1'b1; host_rd_n = 1'b1;
  endtask

  task automatic clear_obs();
    nlog = 0; nexp = 0; irq_cnt = 0; rd_idx = 0;
    rb_rise_cyc = -1; first_rd_cyc = -1; irq_cyc = -1; busy_seen = 0;
  endtask

  task automatic ex(input logic [1:0] k, input logic [15:0] d);
    ek[nexp] = k; ed[nexp] = d; nexp++;
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && irq_cnt == 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    bit ok = (nlog == nexp);
    int bad = -1;
    if (ok) for (int i = 0; i < nexp; i++)
      if (bad < 0 && (logk[i] != ek[i] || logd[i] != ed[i])) bad = i;
    if (!ok) check(0, req, "cycle count", nlog, nexp);
    else if (bad >= 0) check(0, req, "cycle kind/data", {14'd0, logk[bad], logd[bad]}, {14'd0, ek[bad], ed[bad]});
    else check(1, req, "cycle order", 0, 0);
  endtask

  task automatic check_done(input string req);
    check(irq_cnt == 1, "R10", {req, " single irq"}, irq_cnt, 1);
    check(host_rb_n == 1'b1, "R10", {req, " ready after"}, {31'd0, host_rb_n}, 1);
  endtask

  task automatic check_wait(input string req);
    check(busy_seen == 1 && irq_cyc > rb_rise_cyc, req, "irq after busy release", irq_cyc, rb_rise_cyc);
  endtask

  localparam logic [31:0] FADDR = 32'h0003_0A42;
  localparam logic [31:0] WWORD = 32'hBEEF_1234;

  initial begin : wd
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R14 / R1 during reset
    check(tgt_wp_n == 1'b0, "R14", "wp_n in reset", {31'd0, tgt_wp_n}, 0);
    check(host_rb_n == 1'b1 && host_irq == 1'b0, "R1", "host outputs in reset",
          {30'd0, host_rb_n, host_irq}, 32'h2);
    host_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({tgt_ce_n, tgt_we_n, tgt_re_n, tgt_cle, tgt_ale} == 5'b11100, "R1", "target pins idle",
          {27'd0, tgt_ce_n, tgt_we_n, tgt_re_n, tgt_cle, tgt_ale}, 32'h1C);
    check(host_rb_n == 1'b1 && host_irq == 1'b0, "R1", "host outputs after reset",
          {30'd0, host_rb_n, host_irq}, 32'h2);
    check(tgt_wp_n == 1'b1, "R14", "wp_n released", {31'd0, tgt_wp_n}, 1);

    host_wr(12'h004, FADDR);
    host_wr(12'h010, WWORD);
    host_rd(12'h004, rv);
    check(rv == FADDR, "R2", "address register readback", rv, FADDR);

    // R3 / R4 / R5 / R6 page read
    clear_obs(); rd_base = 16'h5A00;
    host_wr(12'h000, 32'h00);
    repeat (20) @(negedge clk);
    check(nlog == 0 && host_rb_n, "R3", "first byte alone idle", nlog, 0);
    host_wr(12'h000, 32'h30);
    check(host_rb_n == 1'b0, "R10", "busy after confirm", {31'd0, host_rb_n}, 0);
    wait_irq(400);
    ex(0, 16'h00); ex(1, 16'h0A42); ex(1, 16'h0003); ex(0, 16'h30);
    ex(3, 16'h5A00); ex(3, 16'h5A01);
    cmp_log("R4");
    check_done("read");
    check_wait("R5");
    check(first_rd_cyc > rb_rise_cyc, "R5", "read after busy release", first_rd_cyc, rb_rise_cyc);
    host_rd(12'h010, rv);
    check(rv == 32'h5A01_5A00, "R6", "page read word", rv, 32'h5A01_5A00);

    // R4 program
    clear_obs();
    host_wr(12'h000, 32'h80);
    host_wr(12'h000, 32'h10);
    wait_irq(400);
    ex(0, 16'h80); ex(1, 16'h0A42); ex(1, 16'h0003); ex(2, 16'h1234); ex(2, 16'hBEEF); ex(0, 16'h10);
    cmp_log("R4");
    check_done("program");
    check_wait("R5");

    // R4 erase, with R11 opcode writes during busy
    clear_obs();
    host_wr(12'h000, 32'h60);
    host_wr(12'h000, 32'hD0);
    repeat (3) @(negedge clk);
    host_wr(12'h000, 32'h70);
    host_wr(12'h000, 32'h90);
    wait_irq(400);
    repeat (60) @(negedge clk);
    ex(0, 16'h60); ex(1, 16'h0A42); ex(1, 16'h0003); ex(0, 16'hD0);
    cmp_log("R11");
    check_done("erase");
    check_wait("R5");

    // R7 read ID
    clear_obs(); rd_base = 16'hC0D0;
    host_wr(12'h000, 32'h90);
    wait_irq(400);
    ex(0, 16'h90); ex(3, 16'hC0D0); ex(3, 16'hC0D1);
    cmp_log("R7");
    check(busy_seen == 0, "R7", "no busy wait", busy_seen, 0);
    check_done("id");
    host_rd(12'h008, rv);
    check(rv == 32'hC0D1_C0D0, "R7", "id register", rv, 32'hC0D1_C0D0);

    // R8 read status
    clear_obs(); rd_base = 16'h12E1;
    host_wr(12'h000, 32'h70);
    wait_irq(400);
    ex(0, 16'h70); ex(3, 16'h12E1);
    cmp_log("R8");
    check_done("status");
    host_rd(12'h00C, rv);
    check(rv == 32'h0000_00E1, "R8", "status register", rv, 32'hE1);

    // R9 target reset
    clear_obs();
    host_wr(12'h000, 32'hFF);
    wait_irq(400);
    ex(0, 16'hFF);
    cmp_log("R9");
    check_done("reset");
    check_wait("R9");

    // R3 mismatched pairs
    for (int f = 0; f < 3; f++) begin
      for (int c = 0; c < 3; c++) begin
        if (f != c) begin
          logic [7:0] fb, cb;
          fb = (f == 0) ? 8'h00 : (f == 1) ? 8'h80 : 8'h60;
          cb = (c == 0) ? 8'h30 : (c == 1) ? 8'h10 : 8'hD0;
          clear_obs();
          host_wr(12'h000, {24'd0, fb});
          host_wr(12'h000, {24'd0, cb});
          repeat (40) @(negedge clk);
          check(nlog == 0 && irq_cnt == 0 && host_rb_n, "R3", "mismatched pair ignored",
                {fb, cb, 8'd0, 8'(nlog)}, {fb, cb, 16'd0});
        end
      end
    end

    // R12 stored first byte discarded by unrecognised byte
    clear_obs();
    host_wr(12'h000, 32'h00);
    host_wr(12'h000, 32'h55);
    host_wr(12'h000, 32'h30);
    repeat (40) @(negedge clk);
    check(nlog == 0 && irq_cnt == 0, "R12", "pending first byte cleared", nlog, 0);

    // R2 opcodes at non-command offsets
    clear_obs();
    host_wr(12'h020, 32'h90);
    host_wr(12'h008, 32'h70);
    host_wr(12'h00C, 32'hFF);
    repeat (40) @(negedge clk);
    check(nlog == 0 && irq_cnt == 0 && host_rb_n, "R2", "opcode off command slot", nlog, 0);

    // R12 sweep of every opcode byte
    for (int v = 0; v < 256; v++) begin
      host_wr(12'h000, 32'h01);
      clear_obs(); rd_base = 16'h0700;
      host_wr(12'h000, 32'(v));
      if (v == 8'h90 || v == 8'h70 || v == 8'hFF) begin
        wait_irq(400);
        check(irq_cnt == 1 && nlog > 0 && logk[0] == 2'd0 && logd[0] == 16'(v), "R12",
              "single-byte opcode runs", {8'(v), 8'(irq_cnt), 16'(nlog)}, {8'(v), 8'd1, 16'd0});
      end else begin
        repeat (20) @(negedge clk);
        check(irq_cnt == 0 && nlog == 0 && host_rb_n, "R12", "byte starts nothing",
              {8'(v), 8'(irq_cnt), 16'(nlog)}, {8'(v), 24'd0});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule